// File: doc/BRIEF.md
# Branch Direction Predictor with Saturating Counters

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters, 512 entries by default, in one block-RAM style memory. The table is indexed by the word-address bits of the branch. A lookup presents the branch address, a flag that marks branches whose direction depends only on condition-register state, and a static hint. The registered prediction appears two clocks later. An update port presents the resolved branch address and its actual outcome, and the matching counter moves one step toward that outcome.

Only condition-register-only branches read the table. All other branches, and every branch while the table is off, follow the static hint. After reset an internal sweep writes the weakly not-taken state into every entry, one entry per clock. While the sweep runs the table acts as disabled, whatever the enable input says.

Top module: `bht_predictor`

## Requirements
- R1: The index is address bits [10:2], so the table has 512 entries. Addresses that differ only outside those bits share one counter, and different indices are independent.
- R2: After synchronous reset the block spends 512 clocks writing state 01 into every entry. During that time lookups return the hint and updates are dropped. After it, every entry predicts not-taken, and a single taken update makes it predict taken.
- R3: Counter encoding: 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. A table-based prediction is the counter's most significant bit.
- R4: A taken update increments the counter and stops at 11. A not-taken update decrements it and stops at 00.
- R5: While `enable` is low, condition-register-only lookups return the hint, and updates leave the table unchanged. The unchanged state can be seen once `enable` is high again.
- R6: A lookup with `lk_cr_only` low returns `lk_hint`, whatever the table holds and whatever the value of `enable`.
- R7: `pred_taken` is a register. It shows the result for the lookup inputs sampled two rising edges earlier, and it is 0 while `rst` is high.
- R8: Updates to the same index on consecutive clocks each take effect, with none lost.
- R9: An update sampled at edge E is seen by lookups sampled at edge E+2 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Table use and training enable |
| lk_addr | input | 32 | Lookup branch address |
| lk_cr_only | input | 1 | Branch direction depends only on condition-register state |
| lk_hint | input | 1 | Static prediction for this branch |
| upd_valid | input | 1 | Update strobe |
| upd_addr | input | 32 | Resolved branch address |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
A wrong counter shows up only through `pred_taken` on a later condition-register-only lookup with `enable` high, two clocks after that lookup. A counter that is off by one step stays hidden until its most significant bit differs from the correct one. For that reason the stimulus keeps a few indices in use so that counters cross between 01 and 10 and saturate at both ends. A lost back-to-back update, or a write to the wrong index, changes the prediction of the next lookup to that index. The bench keeps a shadow table that applies each update at the same edge as the design, so every lookup is compared with its expected value.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_ST)  ? c : c + 2'b01;
    else       r = (c == CTR_SNT) ? c : c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/bht_ram.sv
module bht_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write: a read at the same address as a write sees the old word.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/bht_init_sweep.sv
module bht_init_sweep #(
  parameter int ENTRIES = 512,
  parameter int IDX_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] wr_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end
  end

  assign wr_idx = ptr;

  // R2
  sweep_done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R2
  sweep_ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/bht_update_pipe.sv
module bht_update_pipe
  import bht_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  ctr_t             rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_data
);

  logic             s_vld;
  logic [IDX_W-1:0] s_idx;
  logic             s_taken;
  logic             fwd;
  ctr_t             fwd_val;
  ctr_t             base;
  logic             accept;

  assign accept = upd_valid & active;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld <= 1'b0;
      fwd   <= 1'b0;
    end else begin
      s_vld <= accept;
      // The RAM read for the incoming update misses the write made at this edge.
      fwd   <= accept & s_vld & (s_idx == upd_idx);
    end
    s_idx   <= upd_idx;
    s_taken <= upd_taken;
    fwd_val <= wr_data;
  end

  assign base    = fwd ? fwd_val : rd_data;
  assign wr_data = ctr_step(base, s_taken);
  assign wr_en   = s_vld;
  assign wr_idx  = s_idx;

  // R5
  upd_only_when_active_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(active) && $past(upd_valid)));

  // R8
  fwd_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    fwd |-> $past(wr_en));

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_cr_only,
  input  logic              lk_hint,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  output logic              pred_taken
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             sweep_busy;
  logic [IDX_W-1:0] sweep_idx;
  logic             active;
  ctr_t             lk_ctr, up_ctr;
  logic             u_wr_en;
  logic [IDX_W-1:0] u_wr_idx;
  ctr_t             u_wr_data;
  logic             ram_we;
  logic [IDX_W-1:0] ram_wa;
  ctr_t             ram_wd;
  logic             s1_use, s1_hint;
  logic             unused_addr_bits;

  assign lk_idx = lk_addr[IDX_MSB:IDX_LSB];
  assign up_idx = upd_addr[IDX_MSB:IDX_LSB];
  assign unused_addr_bits = ^{lk_addr[ADDR_W-1:IDX_MSB+1], lk_addr[IDX_LSB-1:0],
                              upd_addr[ADDR_W-1:IDX_MSB+1], upd_addr[IDX_LSB-1:0]};

  assign active = enable & ~sweep_busy;

  bht_init_sweep #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sweep (
    .clk    (clk),
    .rst    (rst),
    .busy   (sweep_busy),
    .wr_idx (sweep_idx)
  );

  bht_update_pipe #(.IDX_W(IDX_W)) u_upd (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .upd_valid (upd_valid),
    .upd_idx   (up_idx),
    .upd_taken (upd_taken),
    .rd_data   (up_ctr),
    .wr_en     (u_wr_en),
    .wr_idx    (u_wr_idx),
    .wr_data   (u_wr_data)
  );

  // The sweep owns the write port until it finishes.
  assign ram_we = sweep_busy | u_wr_en;
  assign ram_wa = sweep_busy ? sweep_idx : u_wr_idx;
  assign ram_wd = sweep_busy ? CTR_WNT   : u_wr_data;

  bht_ram #(.DEPTH(ENTRIES), .AW(IDX_W), .DW(2)) u_ram (
    .clk     (clk),
    .ra_addr (lk_idx),
    .ra_data (lk_ctr),
    .rb_addr (up_idx),
    .rb_data (up_ctr),
    .we      (ram_we),
    .wa      (ram_wa),
    .wd      (ram_wd)
  );

  // Lookup stage 1 runs alongside the RAM read; stage 2 is the output register.
  always_ff @(posedge clk) begin
    s1_use  <= active & lk_cr_only;
    s1_hint <= lk_hint;
    if (rst) pred_taken <= 1'b0;
    else     pred_taken <= s1_use ? lk_ctr[1] : s1_hint;
  end

  logic [1:0] chk_seen;
  always_ff @(posedge clk) begin
    if (rst)                 chk_seen <= 2'd0;
    else if (chk_seen != 2'd2) chk_seen <= chk_seen + 2'd1;
  end

  // R2
  no_upd_during_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |-> !u_wr_en);

  // R6
  static_path_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_seen == 2'd2 && !$past(lk_cr_only, 2)) |-> (pred_taken == $past(lk_hint, 2)));

  // R5
  disabled_path_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_seen == 2'd2 && !$past(enable, 2)) |-> (pred_taken == $past(lk_hint, 2)));

  // R7
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> !pred_taken);

endmodule

// File: tb/sim_bht_predictor.sv
`timescale 1ns/1ps
module sim_bht_predictor;

  localparam int N = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_cr_only = 1'b0;
  logic        lk_hint = 1'b0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic        pred_taken;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bht_predictor u0 (
    .clk(clk), .rst(rst), .enable(enable), .lk_addr(lk_addr),
    .lk_cr_only(lk_cr_only), .lk_hint(lk_hint), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_taken(upd_taken), .pred_taken(pred_taken)
  );

  logic [1:0] model [N];
  logic       sweeping = 1'b1;
  // Lookup expectation pipeline (index 1 is oldest)
  logic  q_v [2];
  logic  q_e [2];
  string q_r [2];
  // Pending model updates (a is oldest)
  logic       pa_v = 0, pb_v = 0;
  logic [8:0] pa_i, pb_i;
  logic       pa_t, pb_t;

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic [8:0] ix(input logic [31:0] a);
    return a[10:2];
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pred_taken=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [31:0] la, input logic cr, input logic hint,
                       input logic en, input logic uv, input logic [31:0] ua,
                       input logic ut, input logic chk, input string req);
    @(negedge clk);
    if (q_v[1]) check(pred_taken, q_e[1], q_r[1]);
    if (pa_v) model[pa_i] = step(model[pa_i], pa_t);
    pa_v = pb_v; pa_i = pb_i; pa_t = pb_t;
    pb_v = uv && en && !sweeping; pb_i = ix(ua); pb_t = ut;
    q_v[1] = q_v[0]; q_e[1] = q_e[0]; q_r[1] = q_r[0];
    q_v[0] = chk;
    q_e[0] = (cr && en && !sweeping) ? model[ix(la)][1] : hint;
    q_r[0] = req;
    lk_addr = la; lk_cr_only = cr; lk_hint = hint; enable = en;
    upd_valid = uv; upd_addr = ua; upd_taken = ut;
  endtask

  task automatic look(input logic [31:0] a, input logic cr, input logic hint,
                      input logic en, input string req);
    drive(a, cr, hint, en, 1'b0, 32'h0, 1'b0, 1'b1, req);
  endtask

  task automatic upd(input logic [31:0] a, input logic t, input logic en);
    drive(32'h0, 1'b0, 1'b0, en, 1'b1, a, t, 1'b0, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "");
  endtask

  function automatic logic [31:0] mk(input logic [8:0] i, input logic [31:0] r);
    return {r[31:11], i, r[1:0]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    q_v[0] = 0; q_v[1] = 0;
    for (int i = 0; i < N; i++) model[i] = 2'b01;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(pred_taken, 1'b0, "R7 reset value");
    rst = 1'b0;

    // R2: during the sweep, lookups follow the hint and updates are dropped
    for (int i = 0; i < 20; i++) begin
      look(mk(9'd3, $urandom), 1'b1, i[0], 1'b1, "R2 sweep static");
      drive(32'h0, 1'b0, 1'b0, 1'b1, 1'b1, mk(9'd4, $urandom), 1'b1, 1'b0, "");
    end
    idle(560);
    sweeping = 1'b0;

    // R2 / R3: weakly not-taken everywhere after the sweep
    look(mk(9'd0, 0), 1'b1, 1'b1, 1'b1, "R2 entry 0 after sweep");
    look(mk(9'd511, 0), 1'b1, 1'b1, 1'b1, "R2 entry 511 after sweep");
    look(mk(9'd4, 0), 1'b1, 1'b1, 1'b1, "R2 sweep-time update dropped");
    upd(mk(9'd7, 0), 1'b1, 1'b1);
    idle(1);
    look(mk(9'd7, 0), 1'b1, 1'b0, 1'b1, "R3 one taken step gives weakly taken");
    look(mk(9'd8, 0), 1'b1, 1'b1, 1'b1, "R1 neighbour index untouched");

    // R8 / R4: back-to-back taken updates saturate
    for (int i = 0; i < 5; i++) upd(mk(9'd9, $urandom), 1'b1, 1'b1);
    upd(mk(9'd9, 0), 1'b0, 1'b1);
    idle(1);
    look(mk(9'd9, 0), 1'b1, 1'b0, 1'b1, "R4 saturated high then one decrement");
    for (int i = 0; i < 4; i++) upd(mk(9'd9, 0), 1'b0, 1'b1);
    idle(1);
    look(mk(9'd9, 0), 1'b1, 1'b1, 1'b1, "R4 saturated low");
    upd(mk(9'd9, 0), 1'b1, 1'b1);
    idle(1);
    look(mk(9'd9, 0), 1'b1, 1'b1, 1'b1, "R8 low saturation kept count");

    // R9: the lookup one edge after the update edge still sees the old state
    drive(32'h0, 1'b0, 1'b0, 1'b1, 1'b1, mk(9'd20, 0), 1'b1, 1'b0, "");
    look(mk(9'd20, 0), 1'b1, 1'b0, 1'b1, "R9 old value on the next edge");
    look(mk(9'd20, 0), 1'b1, 1'b1, 1'b1, "R9 new value two edges later");

    // R1: aliasing through upper and lower address bits
    look({21'h1abcd, 9'd7, 2'b11}, 1'b1, 1'b0, 1'b1, "R1 alias shares counter");

    // R5: disabled lookups and updates
    look(mk(9'd9, 0), 1'b1, 1'b1, 1'b0, "R5 disabled uses hint");
    for (int i = 0; i < 3; i++) upd(mk(9'd30, 0), 1'b1, 1'b0);
    idle(1);
    look(mk(9'd30, 0), 1'b1, 1'b1, 1'b1, "R5 disabled updates dropped");

    // R6: non-CR branches ignore the table
    look(mk(9'd7, 0), 1'b0, 1'b0, 1'b1, "R6 non-CR branch uses hint");
    look(mk(9'd0, 0), 1'b0, 1'b1, 1'b1, "R6 non-CR branch uses hint");

    // Random mix over a small index set
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      logic [8:0]  li = 9'(r[2:0] + 9'd100);
      logic [8:0]  ui = 9'(r[5:3] + 9'd100);
      drive(mk(li, $urandom), r[8] | r[9], r[10], r[11] | r[12] | r[13],
            r[14] | r[15], mk(ui, $urandom), r[16] | r[17], 1'b1,
            "R4 R7 R8 random mix");
    end
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule